// File: doc/BRIEF.md
# Single-Precision Floating-Point Subtractor

This unit computes the difference x − y of two IEEE 754 binary32 operands under one of four rounding modes. It gives back the rounded result and four exception flags: invalid, overflow, underflow and inexact. The datapath is combinational and ends in a single output register, so a result appears one clock after its operands are presented. A new operand pair can be applied on every cycle.

Each operand is sorted into one of six classes: zero, normal, subnormal, infinity, quiet NaN or signalling NaN. Any pair that includes a NaN, an infinity or a zero is settled by a fixed priority chain and never reaches the arithmetic. Every other pair goes through the add datapath with y's sign inverted. That datapath normalizes subnormal operands, aligns the two significands with three extra low bits (guard, round, sticky), adds or subtracts the magnitudes, renormalizes, rounds and packs the result.

Top module: `fsub_unit`

## Requirements
- R1: The result and flag outputs are registered and show the outcome of the inputs sampled at the previous rising clock edge. While reset is low, every output is zero.
- R2: The rounding-mode input is encoded as 0 = nearest-even, 1 = toward zero, 2 = toward +infinity and 3 = toward −infinity. An inexact finite result is rounded in that mode, and inexact is raised whenever any guard, round or sticky bit is nonzero.
- R3: If the rounded magnitude is too large for binary32, overflow and inexact are raised. The result is infinity in nearest-even mode, the largest finite value in toward-zero mode, and in the two directed modes infinity only when the result sign matches the rounding direction (largest finite value otherwise).
- R4: If both operands are nonzero finite and the exact result lies below the smallest normal magnitude, the result is packed as a subnormal with exponent field 0 and underflow is raised.
- R5: A signalling NaN in x gives x with fraction bit 22 set, and invalid is raised. Otherwise a signalling NaN in y gives y with bit 22 set, and invalid is raised.
- R6: If neither operand is a signalling NaN, a quiet NaN in x is returned unchanged. Otherwise a quiet NaN in y is returned unchanged. No flag is raised in either case.
- R7: Infinity minus infinity of the same sign returns 0x7FC00000 and raises invalid. With opposite signs it returns x. A finite x minus an infinite y returns infinity with the sign opposite to y's. An infinite x minus a finite y returns x.
- R8: Zero minus zero with opposite signs returns x. With equal signs it returns +0, or −0 in mode 3.
- R9: A nonzero finite x minus a zero returns x. A zero x minus a nonzero finite y returns y with bit 31 inverted.
- R10: An exact cancellation of two nonzero finite operands gives +0, or −0 in mode 3, and raises no flag.
- R11: When the effective operation is an addition and the significand sum carries out, the sum is shifted right with its sticky bit kept and the exponent is incremented (for example 1.0 − (−1.0) = 2.0).
- R12: When one exponent is far below the other, the smaller operand still affects rounding through the sticky bit. For example, 1.0 − 2^−30 rounds to 1.0 in mode 0 and to 0x3F7FFFFF in mode 1.
- R13: A special-pair result never raises overflow, underflow or inexact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_x | input | 32 | Minuend, binary32 |
| op_y | input | 32 | Subtrahend, binary32 |
| rnd_mode | input | 2 | Rounding mode (see R2) |
| diff | output | 32 | Registered result x − y |
| flag_invalid | output | 1 | Invalid operation |
| flag_overflow | output | 1 | Result overflowed |
| flag_underflow | output | 1 | Result is subnormal |
| flag_inexact | output | 1 | Result was rounded |

## Verification
The situations hardest to reach from the ports are the ones that depend on the exact alignment distance. These include a round-to-nearest tie (a half-ulp remainder with a clean sticky), a sticky-only contribution from an operand more than 27 binades lower, and a difference that falls below the normal range after normalizing a subnormal operand. Random operands almost never hit these cases. The stimulus therefore uses operand pairs whose exponent gap is chosen by hand: 1 − 2^−25 for the tie, 1 − 2^−30 for sticky only, and the smallest normal minus the smallest subnormal for underflow. Each of these pairs is applied under several rounding modes.

// File: rtl/fsub_pkg.sv
package fsub_pkg;
  localparam int EXP_W     = 8;
  localparam int FRAC_W    = 23;
  localparam int WORD_W    = 1 + EXP_W + FRAC_W;
  localparam int SIG_W     = FRAC_W + 1;
  localparam int GRS_W     = 3;
  localparam int EXT_W     = SIG_W + GRS_W;
  localparam int SE_W      = EXP_W + 2;
  localparam int EXP_MAX   = (1 << EXP_W) - 1;
  localparam int QUIET_BIT = FRAC_W - 1;

  localparam logic [WORD_W-1:0] DEFAULT_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_TO_POS    = 2'd2,
    RM_TO_NEG    = 2'd3
  } rmode_e;

  typedef enum logic [2:0] {
    CL_ZERO, CL_NORM, CL_SUB, CL_INF, CL_QNAN, CL_SNAN
  } opclass_e;

  typedef struct packed {
    logic                   sign;
    opclass_e               cls;
    logic signed [SE_W-1:0] exp;
    logic [SIG_W-1:0]       sig;
  } operand_t;

  // leading zero count of an extended significand; EXT_W when all zero
  function automatic int lead_zeros(input logic [EXT_W-1:0] v);
    int   n;
    logic found;
    n = EXT_W;
    found = 1'b0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!found && v[i]) begin
        n = EXT_W - 1 - i;
        found = 1'b1;
      end
    end
    return n;
  endfunction

  // right shift that folds every lost bit into bit 0
  function automatic logic [EXT_W-1:0] shr_sticky(input logic [EXT_W-1:0] v,
                                                  input int amt);
    logic [EXT_W-1:0] r;
    logic             lost;
    if (amt <= 0) return v;
    if (amt >= EXT_W) return {{(EXT_W-1){1'b0}}, |v};
    r = v >> amt;
    lost = 1'b0;
    for (int i = 0; i < EXT_W; i++) begin
      if (i < amt && v[i]) lost = 1'b1;
    end
    r[0] = r[0] | lost;
    return r;
  endfunction

  function automatic logic round_up(input rmode_e rm, input logic sign,
                                    input logic lsb, input logic [GRS_W-1:0] grs);
    logic tail;
    tail = |grs;
    case (rm)
      RM_NEAR_EVEN: return grs[GRS_W-1] & ((|grs[GRS_W-2:0]) | lsb);
      RM_TO_ZERO:   return 1'b0;
      RM_TO_POS:    return tail & ~sign;
      default:      return tail & sign;
    endcase
  endfunction

  function automatic logic ovf_goes_inf(input rmode_e rm, input logic sign);
    case (rm)
      RM_NEAR_EVEN: return 1'b1;
      RM_TO_ZERO:   return 1'b0;
      RM_TO_POS:    return ~sign;
      default:      return sign;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] make_quiet(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    r[QUIET_BIT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/fsub_unpack.sv
module fsub_unpack
  import fsub_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output operand_t          opnd
);
  logic [EXP_W-1:0]  efield;
  logic [FRAC_W-1:0] ffield;
  logic              exp_zero;
  logic              exp_ones;
  logic [EXT_W-1:0]  raw_ext;
  logic [EXT_W-1:0]  norm_ext;
  int                lz;

  assign efield = word[WORD_W-2 -: EXP_W];
  assign ffield = word[FRAC_W-1:0];

  always_comb begin
    exp_zero = (efield == '0);
    exp_ones = &efield;
    raw_ext  = {~exp_zero, ffield, {GRS_W{1'b0}}};
    lz       = lead_zeros(raw_ext);
    norm_ext = raw_ext << lz;

    opnd.sign = word[WORD_W-1];
    opnd.sig  = norm_ext[EXT_W-1 -: SIG_W];
    opnd.exp  = exp_zero ? SE_W'(1 - lz) : SE_W'(efield);

    if (exp_zero)
      opnd.cls = (ffield == '0) ? CL_ZERO : CL_SUB;
    else if (exp_ones) begin
      if (ffield == '0)          opnd.cls = CL_INF;
      else if (ffield[QUIET_BIT]) opnd.cls = CL_QNAN;
      else                       opnd.cls = CL_SNAN;
    end else
      opnd.cls = CL_NORM;
  end
endmodule

// File: rtl/fsub_special.sv
module fsub_special
  import fsub_pkg::*;
(
  input  logic [WORD_W-1:0] x_word,
  input  logic [WORD_W-1:0] y_word,
  input  opclass_e          x_cls,
  input  opclass_e          y_cls,
  input  rmode_e            rm,
  output logic              hit,
  output logic [WORD_W-1:0] res,
  output logic              invalid
);
  logic xs;
  logic ys;

  assign xs = x_word[WORD_W-1];
  assign ys = y_word[WORD_W-1];

  always_comb begin
    hit     = 1'b1;
    res     = '0;
    invalid = 1'b0;
    if (x_cls == CL_SNAN) begin
      res = make_quiet(x_word);
      invalid = 1'b1;
    end else if (y_cls == CL_SNAN) begin
      res = make_quiet(y_word);
      invalid = 1'b1;
    end else if (x_cls == CL_QNAN)
      res = x_word;
    else if (y_cls == CL_QNAN)
      res = y_word;
    else if (x_cls == CL_INF && y_cls == CL_INF) begin
      if (xs == ys) begin
        res = DEFAULT_NAN;
        invalid = 1'b1;
      end else
        res = x_word;
    end else if (y_cls == CL_INF)
      res = {~ys, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (x_cls == CL_INF)
      res = x_word;
    else if (x_cls == CL_ZERO && y_cls == CL_ZERO)
      res = (xs != ys) ? x_word : {(rm == RM_TO_NEG), {(WORD_W-1){1'b0}}};
    else if (y_cls == CL_ZERO)
      res = x_word;
    else if (x_cls == CL_ZERO)
      res = {~ys, y_word[WORD_W-2:0]};
    else
      hit = 1'b0;
  end
endmodule

// File: rtl/fsub_addsub.sv
module fsub_addsub
  import fsub_pkg::*;
(
  input  logic                   x_sign,
  input  logic signed [SE_W-1:0] x_exp,
  input  logic [SIG_W-1:0]       x_sig,
  input  logic                   y_sign,
  input  logic signed [SE_W-1:0] y_exp,
  input  logic [SIG_W-1:0]       y_sig,
  output logic                   r_sign,
  output logic signed [SE_W-1:0] r_exp,
  output logic [EXT_W-1:0]       r_sig,
  output logic                   carry_out,
  output logic                   cancel
);
  logic                   y_eff;
  logic                   same;
  logic [EXT_W-1:0]       xm, ym, xa, ya;
  logic signed [SE_W-1:0] e_al;
  logic [EXT_W:0]         mag_sum;
  logic [EXT_W-1:0]       mag_diff;
  logic                   x_ge;
  int                     ediff;
  int                     lz;

  always_comb begin
    y_eff = ~y_sign;
    xm = {x_sig, {GRS_W{1'b0}}};
    ym = {y_sig, {GRS_W{1'b0}}};
    if (x_exp >= y_exp) begin
      ediff = int'(x_exp - y_exp);
      xa    = xm;
      ya    = shr_sticky(ym, ediff);
      e_al  = x_exp;
    end else begin
      ediff = int'(y_exp - x_exp);
      xa    = shr_sticky(xm, ediff);
      ya    = ym;
      e_al  = y_exp;
    end

    same     = (x_sign == y_eff);
    mag_sum  = {1'b0, xa} + {1'b0, ya};
    x_ge     = (xa >= ya);
    mag_diff = x_ge ? (xa - ya) : (ya - xa);
    lz       = lead_zeros(mag_diff);

    carry_out = 1'b0;
    cancel    = 1'b0;
    if (same) begin
      r_sign = x_sign;
      if (mag_sum[EXT_W]) begin
        carry_out = 1'b1;
        r_sig     = mag_sum[EXT_W:1];
        r_sig[0]  = mag_sum[1] | mag_sum[0];
        r_exp     = e_al + SE_W'(1);
      end else begin
        r_sig = mag_sum[EXT_W-1:0];
        r_exp = e_al;
      end
    end else begin
      r_sign = x_ge ? x_sign : y_eff;
      cancel = (mag_diff == '0);
      r_sig  = mag_diff << lz;
      r_exp  = e_al - SE_W'(lz);
    end
  end
endmodule

// File: rtl/fsub_round.sv
module fsub_round
  import fsub_pkg::*;
(
  input  logic                   sign,
  input  logic signed [SE_W-1:0] exp_in,
  input  logic [EXT_W-1:0]       sig_in,
  input  rmode_e                 rm,
  output logic [WORD_W-1:0]      word,
  output logic                   overflow,
  output logic                   underflow,
  output logic                   inexact
);
  localparam logic signed [SE_W-1:0] ONE_E  = SE_W'(1);
  localparam logic signed [SE_W-1:0] EMAX_E = SE_W'(EXP_MAX);

  logic                   tiny;
  logic [EXT_W-1:0]       dsig;
  logic signed [SE_W-1:0] e1, e2;
  logic [GRS_W-1:0]       grs;
  logic                   up;
  logic [SIG_W:0]         rsum;
  logic [SIG_W-1:0]       rsig;

  always_comb begin
    tiny = (exp_in < ONE_E);
    if (tiny) begin
      dsig = shr_sticky(sig_in, int'(ONE_E - exp_in));
      e1   = ONE_E;
    end else begin
      dsig = sig_in;
      e1   = exp_in;
    end
    grs  = dsig[GRS_W-1:0];
    up   = round_up(rm, sign, dsig[GRS_W], grs);
    rsum = {1'b0, dsig[EXT_W-1:GRS_W]} + {{SIG_W{1'b0}}, up};
    if (rsum[SIG_W]) begin
      rsig = rsum[SIG_W:1];
      e2   = e1 + SE_W'(1);
    end else begin
      rsig = rsum[SIG_W-1:0];
      e2   = e1;
    end

    overflow  = (e2 >= EMAX_E);
    underflow = tiny;
    inexact   = (|grs) | overflow;
    if (overflow) begin
      if (ovf_goes_inf(rm, sign))
        word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else
        word = {sign, EXP_W'(EXP_MAX - 1), {FRAC_W{1'b1}}};
    end else
      word = {sign, (rsig[SIG_W-1] ? e2[EXP_W-1:0] : {EXP_W{1'b0}}), rsig[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fsub_unit.sv
module fsub_unit
  import fsub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] op_x,
  input  logic [WORD_W-1:0] op_y,
  input  logic [1:0]        rnd_mode,
  output logic [WORD_W-1:0] diff,
  output logic              flag_invalid,
  output logic              flag_overflow,
  output logic              flag_underflow,
  output logic              flag_inexact
);
  localparam int N_OPS = 2;

  logic [WORD_W-1:0] words [N_OPS];
  operand_t          opnds [N_OPS];
  rmode_e            rm;

  // named internal events, observed by the bound checker
  opclass_e               x_cls, y_cls;
  logic                   spec_hit;
  logic [WORD_W-1:0]      spec_res;
  logic                   spec_inv;
  logic                   a_sign;
  logic signed [SE_W-1:0] a_exp;
  logic [EXT_W-1:0]       a_sig;
  logic                   carry_out;
  logic                   cancel_zero;
  logic [WORD_W-1:0]      rnd_word;
  logic                   rnd_ovf, rnd_unf, rnd_inx;
  logic [WORD_W-1:0]      nxt_word;
  logic [3:0]             nxt_flags;

  assign words[0] = op_x;
  assign words[1] = op_y;
  assign rm       = rmode_e'(rnd_mode);

  for (genvar g = 0; g < N_OPS; g++) begin : g_unpack
    fsub_unpack u_unpack (.word(words[g]), .opnd(opnds[g]));
  end

  assign x_cls = opnds[0].cls;
  assign y_cls = opnds[1].cls;

  fsub_special u_special (
    .x_word (op_x),
    .y_word (op_y),
    .x_cls  (x_cls),
    .y_cls  (y_cls),
    .rm     (rm),
    .hit    (spec_hit),
    .res    (spec_res),
    .invalid(spec_inv)
  );

  fsub_addsub u_addsub (
    .x_sign   (opnds[0].sign),
    .x_exp    (opnds[0].exp),
    .x_sig    (opnds[0].sig),
    .y_sign   (opnds[1].sign),
    .y_exp    (opnds[1].exp),
    .y_sig    (opnds[1].sig),
    .r_sign   (a_sign),
    .r_exp    (a_exp),
    .r_sig    (a_sig),
    .carry_out(carry_out),
    .cancel   (cancel_zero)
  );

  fsub_round u_round (
    .sign     (a_sign),
    .exp_in   (a_exp),
    .sig_in   (a_sig),
    .rm       (rm),
    .word     (rnd_word),
    .overflow (rnd_ovf),
    .underflow(rnd_unf),
    .inexact  (rnd_inx)
  );

  always_comb begin
    if (spec_hit) begin
      nxt_word  = spec_res;
      nxt_flags = {spec_inv, 3'b000};
    end else if (cancel_zero) begin
      nxt_word  = {(rm == RM_TO_NEG), {(WORD_W-1){1'b0}}};
      nxt_flags = 4'b0000;
    end else begin
      nxt_word  = rnd_word;
      nxt_flags = {1'b0, rnd_ovf, rnd_unf, rnd_inx};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff           <= '0;
      flag_invalid   <= 1'b0;
      flag_overflow  <= 1'b0;
      flag_underflow <= 1'b0;
      flag_inexact   <= 1'b0;
    end else begin
      diff           <= nxt_word;
      flag_invalid   <= nxt_flags[3];
      flag_overflow  <= nxt_flags[2];
      flag_underflow <= nxt_flags[1];
      flag_inexact   <= nxt_flags[0];
    end
  end
endmodule

// File: rtl/fsub_unit_chk.sv
module fsub_unit_chk
  import fsub_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] op_x,
  input logic [1:0]        rnd_mode,
  input logic [WORD_W-1:0] diff,
  input logic              flag_invalid,
  input logic              flag_overflow,
  input logic              flag_underflow,
  input logic              flag_inexact,
  input logic              spec_hit,
  input logic              cancel_zero,
  input opclass_e          x_cls,
  input opclass_e          y_cls
);
  // R3: overflow always comes with inexact and a saturated exponent
  a_r3_ovf_with_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    flag_overflow |-> (flag_inexact && diff[WORD_W-2 -: EXP_W] >= EXP_W'(EXP_MAX - 1)));

  // R4: an underflowing result is packed with a zero exponent field
  a_r4_unf_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
    flag_underflow |-> (diff[WORD_W-2 -: EXP_W] == '0 && !flag_overflow));

  // R5, R7: invalid only with a quiet NaN result
  a_r5_invalid_gives_qnan: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |-> ((&diff[WORD_W-2 -: EXP_W]) && diff[QUIET_BIT]));

  // R6: a quiet NaN in x wins when no signalling NaN is present
  a_r6_qnan_x_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (x_cls == CL_QNAN && y_cls != CL_SNAN) |=> (diff == $past(op_x) && !flag_invalid));

  // R10: exact cancellation gives a zero signed by the mode
  a_r10_cancel_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel_zero && !spec_hit) |=>
      (diff[WORD_W-2:0] == '0 && diff[WORD_W-1] == ($past(rnd_mode) == 2'd3) &&
       !flag_inexact && !flag_underflow));

  // R13: special pairs never raise arithmetic flags
  a_r13_special_clean: assert property (@(posedge clk) disable iff (!rst_n)
    spec_hit |=> (!flag_overflow && !flag_underflow && !flag_inexact));
endmodule

bind fsub_unit fsub_unit_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_x          (op_x),
  .rnd_mode      (rnd_mode),
  .diff          (diff),
  .flag_invalid  (flag_invalid),
  .flag_overflow (flag_overflow),
  .flag_underflow(flag_underflow),
  .flag_inexact  (flag_inexact),
  .spec_hit      (spec_hit),
  .cancel_zero   (cancel_zero),
  .x_cls         (x_cls),
  .y_cls         (y_cls)
);

// File: tb/fsub_unit_test.sv
`timescale 1ns/1ps
module fsub_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_x = '0;
  logic [31:0] op_y = '0;
  logic [1:0]  rnd_mode = 2'd0;
  logic [31:0] diff;
  logic        flag_invalid, flag_overflow, flag_underflow, flag_inexact;
  int          n_vec = 0;
  int          n_bad = 0;
  logic        done = 1'b0;

  // flag vector order used below: {invalid, overflow, underflow, inexact}
  localparam logic [3:0] F_NONE = 4'b0000, F_INV = 4'b1000, F_OVF = 4'b0101,
                         F_UNF = 4'b0010, F_INX = 4'b0001;
  localparam logic [1:0] RNE = 2'd0, RTZ = 2'd1, RUP = 2'd2, RDN = 2'd3;

  always #10 clk = ~clk;

  fsub_unit uut (
    .clk(clk), .rst_n(rst_n), .op_x(op_x), .op_y(op_y), .rnd_mode(rnd_mode),
    .diff(diff), .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
    .flag_underflow(flag_underflow), .flag_inexact(flag_inexact)
  );

  task automatic compare(input string tag, input logic [31:0] exp_res, input logic [3:0] exp_fl);
    logic [3:0] got_fl;
    got_fl = {flag_invalid, flag_overflow, flag_underflow, flag_inexact};
    n_vec++;
    if (diff !== exp_res || got_fl !== exp_fl) begin
      n_bad++;
      $display("FAIL %s: got %h flags %b, expected %h flags %b", tag, diff, got_fl, exp_res, exp_fl);
    end
  endtask

  task automatic run_vec(input string tag, input logic [31:0] x, input logic [31:0] y,
                         input logic [1:0] rm, input logic [31:0] exp_res, input logic [3:0] exp_fl);
    @(negedge clk);
    op_x = x; op_y = y; rnd_mode = rm;
    @(negedge clk);
    compare(tag, exp_res, exp_fl);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    op_x = 32'h40400000; op_y = 32'h3F800000; rnd_mode = RNE;
    repeat (3) @(negedge clk);
    compare("R1 outputs zero in reset", 32'h0, F_NONE);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 first result after reset", 32'h40000000, F_NONE);
  endtask

  task automatic t_latency;
    run_vec("R1 3-1", 32'h40400000, 32'h3F800000, RNE, 32'h40000000, F_NONE);
    op_x = 32'h3F800000; op_y = 32'h3F800000;
    #2;
    compare("R1 holds until next edge", 32'h40000000, F_NONE);
    @(negedge clk);
    compare("R1 new result one edge later", 32'h00000000, F_NONE);
  endtask

  task automatic t_add_path;
    run_vec("R11 1-(-1) carry", 32'h3F800000, 32'hBF800000, RNE, 32'h40000000, F_NONE);
    run_vec("R11 1.5-(-1.5)", 32'h3FC00000, 32'hBFC00000, RTZ, 32'h40400000, F_NONE);
    run_vec("R2 1-(-2^-24) tie even", 32'h3F800000, 32'hB3800000, RNE, 32'h3F800000, F_INX);
    run_vec("R2 1-(-2^-24) up", 32'h3F800000, 32'hB3800000, RUP, 32'h3F800001, F_INX);
  endtask

  task automatic t_rounding;
    run_vec("R2 1-2^-25 RNE", 32'h3F800000, 32'h33000000, RNE, 32'h3F800000, F_INX);
    run_vec("R2 1-2^-25 RTZ", 32'h3F800000, 32'h33000000, RTZ, 32'h3F7FFFFF, F_INX);
    run_vec("R2 1-2^-25 RUP", 32'h3F800000, 32'h33000000, RUP, 32'h3F800000, F_INX);
    run_vec("R2 1-2^-25 RDN", 32'h3F800000, 32'h33000000, RDN, 32'h3F7FFFFF, F_INX);
    run_vec("R2 1-2^-24 exact", 32'h3F800000, 32'h33800000, RNE, 32'h3F7FFFFF, F_NONE);
    run_vec("R12 1-2^-30 RNE", 32'h3F800000, 32'h30800000, RNE, 32'h3F800000, F_INX);
    run_vec("R12 1-2^-30 RTZ", 32'h3F800000, 32'h30800000, RTZ, 32'h3F7FFFFF, F_INX);
    run_vec("R12 1-2^-30 RUP", 32'h3F800000, 32'h30800000, RUP, 32'h3F800000, F_INX);
  endtask

  task automatic t_overflow;
    run_vec("R3 max-(-max) RNE", 32'h7F7FFFFF, 32'hFF7FFFFF, RNE, 32'h7F800000, F_OVF);
    run_vec("R3 max-(-max) RTZ", 32'h7F7FFFFF, 32'hFF7FFFFF, RTZ, 32'h7F7FFFFF, F_OVF);
    run_vec("R3 max-(-max) RDN", 32'h7F7FFFFF, 32'hFF7FFFFF, RDN, 32'h7F7FFFFF, F_OVF);
    run_vec("R3 -max-max RUP", 32'hFF7FFFFF, 32'h7F7FFFFF, RUP, 32'hFF7FFFFF, F_OVF);
    run_vec("R3 -max-max RDN", 32'hFF7FFFFF, 32'h7F7FFFFF, RDN, 32'hFF800000, F_OVF);
  endtask

  task automatic t_underflow;
    run_vec("R4 minnorm-minsub", 32'h00800000, 32'h00000001, RNE, 32'h007FFFFF, F_UNF);
    run_vec("R4 sub-sub", 32'h00000003, 32'h00000001, RTZ, 32'h00000002, F_UNF);
    run_vec("R4 sub-(-sub) to normal", 32'h00400000, 32'h80400000, RNE, 32'h00800000, F_NONE);
  endtask

  task automatic t_nan;
    run_vec("R5 snan x", 32'h7F800001, 32'h3F800000, RNE, 32'h7FC00001, F_INV);
    run_vec("R5 both snan", 32'h7F800001, 32'hFF800002, RNE, 32'h7FC00001, F_INV);
    run_vec("R5 snan y over qnan x", 32'h7FC00005, 32'h7F800003, RNE, 32'h7FC00003, F_INV);
    run_vec("R6 qnan x", 32'h7FC00005, 32'h3F800000, RNE, 32'h7FC00005, F_NONE);
    run_vec("R6 qnan both", 32'hFFC00009, 32'h7FC00005, RNE, 32'hFFC00009, F_NONE);
    run_vec("R6 qnan y", 32'h3F800000, 32'hFFC00007, RNE, 32'hFFC00007, F_NONE);
  endtask

  task automatic t_inf;
    run_vec("R7 inf-inf", 32'h7F800000, 32'h7F800000, RNE, 32'h7FC00000, F_INV);
    run_vec("R7 inf-(-inf)", 32'h7F800000, 32'hFF800000, RNE, 32'h7F800000, F_NONE);
    run_vec("R7 1-inf", 32'h3F800000, 32'h7F800000, RNE, 32'hFF800000, F_NONE);
    run_vec("R7 0-(-inf)", 32'h00000000, 32'hFF800000, RNE, 32'h7F800000, F_NONE);
    run_vec("R7 -inf-1", 32'hFF800000, 32'h3F800000, RNE, 32'hFF800000, F_NONE);
  endtask

  task automatic t_zero;
    run_vec("R8 +0-+0 RNE", 32'h00000000, 32'h00000000, RNE, 32'h00000000, F_NONE);
    run_vec("R8 +0-+0 RDN", 32'h00000000, 32'h00000000, RDN, 32'h80000000, F_NONE);
    run_vec("R8 -0-+0", 32'h80000000, 32'h00000000, RNE, 32'h80000000, F_NONE);
    run_vec("R8 +0-(-0) RDN", 32'h00000000, 32'h80000000, RDN, 32'h00000000, F_NONE);
    run_vec("R9 1-0", 32'h3F800000, 32'h80000000, RNE, 32'h3F800000, F_NONE);
    run_vec("R9 sub-0", 32'h00000005, 32'h80000000, RNE, 32'h00000005, F_NONE);
    run_vec("R9 0-1", 32'h00000000, 32'h3F800000, RNE, 32'hBF800000, F_NONE);
    run_vec("R9 0-sub", 32'h80000000, 32'h00000001, RNE, 32'h80000001, F_NONE);
    run_vec("R10 1-1 RNE", 32'h3F800000, 32'h3F800000, RNE, 32'h00000000, F_NONE);
    run_vec("R10 1-1 RDN", 32'h3F800000, 32'h3F800000, RDN, 32'h80000000, F_NONE);
    run_vec("R10 sub-sub RUP", 32'h00000007, 32'h00000007, RUP, 32'h00000000, F_NONE);
  endtask

  task automatic t_flags_special;
    run_vec("R13 qnan-1 RUP", 32'h7FC00000, 32'h3F800000, RUP, 32'h7FC00000, F_NONE);
    run_vec("R13 max-inf", 32'h7F7FFFFF, 32'h7F800000, RNE, 32'hFF800000, F_NONE);
  endtask

  task automatic t_midrun_reset;
    run_vec("R1 before reset", 32'h3F800000, 32'hBF800000, RNE, 32'h40000000, F_NONE);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    compare("R1 async clear", 32'h0, F_NONE);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_add_path();
    t_rounding();
    t_overflow();
    t_underflow();
    t_nan();
    t_inf();
    t_zero();
    t_flags_special();
    t_midrun_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule